// File: doc/BRIEF.md
# SM3 message expansion unit

This unit turns one 512-bit message block into the word schedule that the SM3 compression rounds use. The block is accepted in one handshake as sixteen 32-bit lanes. The unit then streams 64 result pairs, one per clock. Each pair holds the schedule word W[j] and the mixed word W'[j] = W[j] ^ W[j+4]. A round index and an end-of-block flag travel with each pair.

Inside, only a 16-entry circular window of recent words is kept. Each cycle the unit generates the word four positions ahead of the one it emits. That lookahead word is written back into the slot of the oldest word, which is no longer needed. The output stream has no backpressure. A new block can be accepted during the final round of the current one, so consecutive blocks stream with no idle cycle between them.

Top module: `sm3_msg_expander`

## Requirements
- R1: Input lane k (k = 0..15) is `inBlock[32k+31:32k]`. W[k] is that lane with its four bytes reversed: lane bits [7:0] become W bits [31:24], and lane bits [31:24] become W bits [7:0]. For rounds 0..15, `outWord` equals W[round].
- R2: For j = 16..67, W[j] = P(W[j-16] ^ W[j-9] ^ rol(W[j-3],15)) ^ rol(W[j-13],7) ^ W[j-6], where P(x) = x ^ rol(x,15) ^ rol(x,23) and rol is a 32-bit left rotate. For rounds 16..63, `outWord` equals W[round].
- R3: For every round j = 0..63, `outMix` equals W[j] ^ W[j+4]. This includes rounds 60..63, which use W[64]..W[67].
- R4: A block is accepted on a rising edge where `inValid` and `inReady` are both high. The pair for round 0 is presented after the second following edge. The remaining 63 pairs follow on consecutive cycles.
- R5: `outRound` counts 0 to 63 within a block. `outLast` is high exactly when a valid pair has round 63.
- R6: `inReady` is high while round 63 is being generated. A block accepted then produces its round 0 on the cycle directly after the previous block's round 63.
- R7: While a block is being expanded and the current round is not 63, `inReady` is low. Any `inValid` and `inBlock` activity in that time has no effect on the stream.
- R8: When no block is being expanded, `outValid` stays low and `inReady` stays high.
- R9: A synchronous reset `rst` aborts any block in progress. After the reset edge, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A block is offered on inBlock |
| inReady | output | 1 | Unit can accept a block this cycle |
| inBlock | input | 512 | Sixteen 32-bit lanes; lane k at bits [32k+31:32k] |
| outValid | output | 1 | Output pair is valid |
| outWord | output | 32 | Schedule word W[round] |
| outMix | output | 32 | Mixed word W[round] ^ W[round+4] |
| outRound | output | 6 | Round index of the pair |
| outLast | output | 1 | Pair is round 63 |

## Verification
The hardest situation to reach from the ports is a second block accepted in the same cycle that round 63 of the first block writes W[67] into the window. There, the load must win without disturbing the last pair. The stimulus reaches it by holding `inValid` high with a new block through the whole expansion of the previous block. The handshake therefore completes exactly on the final round, and the bench repeats this for several blocks in a row. A changing `inBlock` is also held during the busy phase, to show that the window is only written by the genuine accept.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;

  localparam int WORD_W    = 32;
  localparam int WIN_DEPTH = 16;
  localparam int NUM_ROUNDS = 64;
  localparam int LOOKAHEAD = 4;
  localparam int ROUND_W   = $clog2(NUM_ROUNDS);
  localparam int SLOT_W    = $clog2(WIN_DEPTH);
  localparam int BLOCK_W   = WORD_W * WIN_DEPTH;
  localparam int BYTES_PER_WORD = WORD_W / 8;

  // Control to datapath strobes
  typedef struct packed {
    logic               load;   // capture a new block into the window
    logic               step;   // produce one pair this cycle
    logic               last;   // the round being produced is the final one
    logic [ROUND_W-1:0] round;  // round being produced
  } sm3x_strobe_t;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] permP1(input logic [WORD_W-1:0] x);
    return x ^ rotl(x, 15) ^ rotl(x, 23);
  endfunction

  function automatic logic [WORD_W-1:0] byteFlip(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] y;
    for (int b = 0; b < BYTES_PER_WORD; b++) begin
      y[8*(BYTES_PER_WORD-1-b) +: 8] = x[8*b +: 8];
    end
    return y;
  endfunction

endpackage

// File: rtl/sm3x_ctrl.sv
module sm3x_ctrl
  import sm3x_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  output sm3x_strobe_t strobe
);

  localparam logic [ROUND_W-1:0] FINAL_ROUND = ROUND_W'(ROUNDS - 1);

  logic               busy;
  logic [ROUND_W-1:0] roundCnt;
  logic               finalRound;
  logic               loadNow;

  assign finalRound = busy && (roundCnt == FINAL_ROUND);
  assign inReady    = !busy || finalRound;
  assign loadNow    = inValid && inReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      roundCnt <= '0;
    end else if (loadNow) begin
      busy     <= 1'b1;
      roundCnt <= '0;
    end else if (busy) begin
      if (finalRound) begin
        busy <= 1'b0;
      end
      roundCnt <= roundCnt + ROUND_W'(1);
    end
  end

  always_comb begin
    strobe.load  = loadNow && !rst;
    strobe.step  = busy;
    strobe.last  = finalRound;
    strobe.round = roundCnt;
  end

endmodule

// File: rtl/sm3x_path.sv
module sm3x_path
  import sm3x_pkg::*;
#(
  parameter int DEPTH = WIN_DEPTH,
  parameter int AHEAD = LOOKAHEAD
) (
  input  logic                clk,
  input  logic                rst,
  input  sm3x_strobe_t        strobe,
  input  logic [BLOCK_W-1:0]  inBlock,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord,
  output logic [WORD_W-1:0]   outMix,
  output logic [ROUND_W-1:0]  outRound,
  output logic                outLast
);

  localparam int IDX_W = ROUND_W + 1;
  // Slot offsets of each tap relative to the slot of W[t-16], for target W[t]
  localparam logic [SLOT_W-1:0] OFS_M9  = SLOT_W'(DEPTH - 9);
  localparam logic [SLOT_W-1:0] OFS_M3  = SLOT_W'(DEPTH - 3);
  localparam logic [SLOT_W-1:0] OFS_M13 = SLOT_W'(DEPTH - 13);
  localparam logic [SLOT_W-1:0] OFS_M6  = SLOT_W'(DEPTH - 6);

  logic [WORD_W-1:0] win     [DEPTH];
  logic [WORD_W-1:0] swapped [DEPTH];

  // Byte-order conversion of every incoming lane
  for (genvar g = 0; g < DEPTH; g++) begin : gLane
    assign swapped[g] = byteFlip(inBlock[g*WORD_W +: WORD_W]);
  end

  logic [IDX_W-1:0]  aheadIdx;
  logic [SLOT_W-1:0] aheadSlot;
  logic [SLOT_W-1:0] curSlot;
  logic              needGen;
  logic [WORD_W-1:0] tapOld, tapM9, tapM3, tapM13, tapM6;
  logic [WORD_W-1:0] genWord;
  logic [WORD_W-1:0] leadWord;
  logic [WORD_W-1:0] curWord;

  always_comb begin
    aheadIdx  = IDX_W'(strobe.round) + IDX_W'(AHEAD);
    aheadSlot = aheadIdx[SLOT_W-1:0];
    curSlot   = strobe.round[SLOT_W-1:0];
    needGen   = aheadIdx >= IDX_W'(DEPTH);

    tapOld = win[aheadSlot];
    tapM9  = win[aheadSlot + OFS_M9];
    tapM3  = win[aheadSlot + OFS_M3];
    tapM13 = win[aheadSlot + OFS_M13];
    tapM6  = win[aheadSlot + OFS_M6];

    genWord  = permP1(tapOld ^ tapM9 ^ rotl(tapM3, 15)) ^ rotl(tapM13, 7) ^ tapM6;
    leadWord = needGen ? genWord : win[aheadSlot];
    curWord  = win[curSlot];
  end

  // Sliding window: whole-block load wins over the lookahead write
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        win[i] <= '0;
      end
    end else if (strobe.load) begin
      for (int i = 0; i < DEPTH; i++) begin
        win[i] <= swapped[i];
      end
    end else if (strobe.step && needGen) begin
      win[aheadSlot] <= genWord;
    end
  end

  // Registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outWord  <= '0;
      outMix   <= '0;
      outRound <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strobe.step;
      outLast  <= strobe.step && strobe.last;
      if (strobe.step) begin
        outWord  <= curWord;
        outMix   <= curWord ^ leadWord;
        outRound <= strobe.round;
      end
    end
  end

endmodule

// File: rtl/sm3_msg_expander.sv
module sm3_msg_expander
  import sm3x_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [BLOCK_W-1:0] inBlock,
  output logic               outValid,
  output logic [WORD_W-1:0]  outWord,
  output logic [WORD_W-1:0]  outMix,
  output logic [ROUND_W-1:0] outRound,
  output logic               outLast
);

  sm3x_strobe_t       strobe;
  logic               stepActive;
  logic [ROUND_W-1:0] ctrlRound;

  assign stepActive = strobe.step;
  assign ctrlRound  = strobe.round;

  sm3x_ctrl #(.ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .strobe  (strobe)
  );

  sm3x_path #(.DEPTH(WIN_DEPTH), .AHEAD(LOOKAHEAD)) u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inBlock  (inBlock),
    .outValid (outValid),
    .outWord  (outWord),
    .outMix   (outMix),
    .outRound (outRound),
    .outLast  (outLast)
  );

endmodule

// File: rtl/sm3x_checker.sv
module sm3x_checker
  import sm3x_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic               inReady,
  input logic               outValid,
  input logic [ROUND_W-1:0] outRound,
  input logic               outLast,
  input logic               stepActive,
  input logic [ROUND_W-1:0] ctrlRound
);

  localparam logic [ROUND_W-1:0] LAST_R = ROUND_W'(NUM_ROUNDS - 1);

  a_r4_first_round: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> ##1 (outValid && outRound == '0));

  a_r5_round_step: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outLast) |=> (outValid && outRound == $past(outRound) + ROUND_W'(1)));

  a_r5_last_marks_end: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outLast == (outRound == LAST_R)));

  a_r6_after_last: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLast) |=> (!outValid || outRound == '0));

  a_r7_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
    (stepActive && ctrlRound != LAST_R) |-> !inReady);

  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !stepActive |=> !outValid);

  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  always @(posedge clk) begin
    if (rstSeen && !rst) begin
      a_r9_reset_clears: assert (!outValid && inReady);
    end
  end

endmodule

bind sm3_msg_expander sm3x_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inReady    (inReady),
  .outValid   (outValid),
  .outRound   (outRound),
  .outLast    (outLast),
  .stepActive (stepActive),
  .ctrlRound  (ctrlRound)
);

// File: tb/tb_sm3_msg_expander.sv
module tb_sm3_msg_expander;

  logic         clk = 1'b0;
  logic         rst = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [511:0] inBlock = '0;
  logic         outValid;
  logic [31:0]  outWord;
  logic [31:0]  outMix;
  logic [5:0]   outRound;
  logic         outLast;

  sm3_msg_expander dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inBlock(inBlock),
    .outValid(outValid), .outWord(outWord), .outMix(outMix),
    .outRound(outRound), .outLast(outLast)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    int          due;
    logic [31:0] word;
    logic [31:0] mix;
    int          round;
  } expect_t;

  expect_t q[$];
  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  bit  armed = 0;
  bit  finished = 0;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic push_block(input logic [511:0] b);
    logic [31:0] w [68];
    for (int k = 0; k < 16; k++) begin
      logic [31:0] lane;
      lane = b[32*k +: 32];
      w[k] = {lane[7:0], lane[15:8], lane[23:16], lane[31:24]};
    end
    for (int j = 16; j < 68; j++) begin
      logic [31:0] t;
      t = w[j-16] ^ w[j-9] ^ rl(w[j-3], 15);
      w[j] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(w[j-13], 7) ^ w[j-6];
    end
    for (int j = 0; j < 64; j++) begin
      expect_t e;
      e.due = cyc + 2 + j;
      e.word = w[j];
      e.mix = w[j] ^ w[j+4];
      e.round = j;
      q.push_back(e);
    end
  endtask

  // Reference comparison on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (armed && !finished) begin
      if (q.size() <= 2) chk(inReady === 1'b1, (q.size() == 0) ? "R8" : "R6", "inReady high", {31'd0, inReady}, 32'd1);
      else               chk(inReady === 1'b0, "R7", "inReady low", {31'd0, inReady}, 32'd0);
      if (q.size() > 0 && q[0].due == cyc) begin
        chk(outValid === 1'b1, "R4", "outValid", {31'd0, outValid}, 32'd1);
        chk(outWord === q[0].word, (q[0].round < 16) ? "R1" : "R2", "outWord", outWord, q[0].word);
        chk(outMix === q[0].mix, "R3", "outMix", outMix, q[0].mix);
        chk(outRound === 6'(q[0].round), "R5", "outRound", {26'd0, outRound}, q[0].round);
        chk(outLast === (q[0].round == 63), "R5", "outLast", {31'd0, outLast}, {31'd0, q[0].round == 63});
        void'(q.pop_front());
      end else begin
        chk(outValid === 1'b0, "R8", "outValid idle", {31'd0, outValid}, 32'd0);
      end
    end
    if (rst) begin
      q.delete();
      armed = 1;
    end else if (armed && inValid && inReady) begin
      push_block(inBlock);
    end
  end

  task automatic send(input logic [511:0] b);
    inBlock = b;
    inValid = 1'b1;
    do @(negedge clk); while (inReady !== 1'b1);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [511:0] pattern(input int seed);
    logic [511:0] b;
    logic [31:0] s;
    s = 32'h1234_5678 ^ seed;
    for (int k = 0; k < 16; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      b[32*k +: 32] = s;
    end
    return b;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    logic [511:0] cnt;
    for (int k = 0; k < 16; k++) cnt[32*k +: 32] = 32'h6162_6300 + k;

    @(posedge clk); #1;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(6);                          // R8 idle, R9 state after reset

    send(cnt); idle(70);              // R1 R2 R3 R4 R5
    send('0); idle(70);               // all-zero block
    send({512{1'b1}}); idle(70);      // all-ones block

    // R6: three blocks with no gap
    send(pattern(1));
    send(pattern(2));
    send(pattern(3));
    idle(70);

    // R7: offers while busy are ignored
    send(pattern(4));
    inBlock = pattern(5);
    inValid = 1'b1;
    idle(20);
    inBlock = pattern(6);
    idle(10);
    inValid = 1'b0;
    idle(40);

    // R9: reset in the middle of a block
    send(pattern(7));
    idle(25);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    idle(5);
    send(pattern(8)); idle(70);

    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

endmodule